// File: doc/BRIEF.md
# Tracked Point Reliability Filter

This block sits after a point tracker in an object-following pipeline. For every point of a grid inside the target's bounding box it receives three positions and two per-point measures. The positions are where the point started, where forward tracking placed it in the next frame, and where tracking back from that spot landed in the starting frame. The measures are a signed Q1.15 patch similarity and a per-point relative scale ratio in unsigned fixed point. A point is trusted only when its round trip ends close to where it began and its patch still matches well. Every other point is treated as an outlier and discarded.

From the trusted points the block reports the median horizontal and vertical motion and the median scale ratio. Medians are used so that a few bad points that slip through cannot drag the box. One point arrives per clock. A frame opens with a start strobe and closes with a last strobe. The kept values are stored in a small buffer, and after the last point a counting select walks the buffer one candidate per clock to find the medians. The result appears with a one-cycle completion pulse and a flag that says whether any point survived.

Top module: `trk_reliability_filter`

## Requirements
- R1: After reset `est_done` and `est_ok` are 0, `box_dx` and `box_dy` are 0, and `scale_est` is unity (1 << RFRAC, 0x0100 for RFRAC = 8).
- R2: The round-trip error is |org_x − back_x| + |org_y − back_y| in whole pixels. A point passes this test when the error is less than or equal to `fb_limit`; any larger error makes it an outlier.
- R3: A point passes the similarity test when `pt_sim` is greater than or equal to `sim_floor`, both compared as signed Q1.15. A smaller value makes it an outlier.
- R4: `box_dx` is the median over kept points of fwd_x − org_x, and `box_dy` is the median of fwd_y − org_y, both as signed CW+1-bit values. With an even number of kept points the lower of the two middle values, in signed order, is reported.
- R5: `scale_est` is the median of `pt_ratio` over kept points, ordered as unsigned, with the lower middle value taken for an even count.
- R6: A point with `pt_first` set discards everything kept earlier and begins a new frame. The point with `pt_last` set closes the frame, and one point may carry both strobes.
- R7: Only the first MAX_PTS kept points of a frame enter the estimate. Later kept points are dropped.
- R8: A frame with no kept point still completes with `est_done`. It then gives `est_ok` = 0, zero displacement and unity scale. A frame with at least one kept point gives `est_ok` = 1.
- R9: `est_done` is high for one cycle per closed frame. `box_dx`, `box_dy`, `scale_est` and `est_ok` change only in the cycle where `est_done` is high and hold their values otherwise.
- R10: Points presented after `pt_last` and before the matching `est_done` are ignored and do not alter that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_valid | input | 1 | A point is presented this cycle |
| pt_first | input | 1 | This point opens a frame |
| pt_last | input | 1 | This point closes a frame |
| org_x | input | CW | Starting x position |
| org_y | input | CW | Starting y position |
| fwd_x | input | CW | Forward-tracked x position |
| fwd_y | input | CW | Forward-tracked y position |
| back_x | input | CW | Back-tracked x position |
| back_y | input | CW | Back-tracked y position |
| pt_sim | input | SW | Patch similarity, signed Q1.15 |
| pt_ratio | input | RW | Per-point scale ratio, unsigned, RFRAC fraction bits |
| fb_limit | input | CW+1 | Largest round-trip error still accepted |
| sim_floor | input | SW | Smallest similarity still accepted, signed |
| est_done | output | 1 | One-cycle pulse when a frame's result is ready |
| est_ok | output | 1 | At least one point survived in the last frame |
| box_dx | output | CW+1 | Median x motion, signed |
| box_dy | output | CW+1 | Median y motion, signed |
| scale_est | output | RW | Median scale ratio |

## Verification
The properties assume a frame is always closed by `pt_last` and that the thresholds stay constant from a frame's first point until its `est_done`. The bench changes `fb_limit` and `sim_floor` only between frames. It waits for each result before opening the next frame. It keeps coordinates far enough from the edges that forward and back positions never wrap the CW-bit range. The only input that overlaps an evaluation is the deliberate stray point used to show that such input is ignored.

// File: rtl/trk_pkg.sv
package trk_pkg;
   typedef enum logic {
      PH_COLLECT = 1'b0,
      PH_SELECT  = 1'b1
   } trk_phase_e;

   localparam int TRK_NCH = 3;
   localparam int CH_DX   = 0;
   localparam int CH_DY   = 1;
   localparam int CH_RT   = 2;
endpackage

// File: rtl/trk_point_gate.sv
module trk_point_gate #(
   parameter int CW = 12,
   parameter int SW = 16
) (
   input  logic [CW-1:0]        org_x,
   input  logic [CW-1:0]        org_y,
   input  logic [CW-1:0]        back_x,
   input  logic [CW-1:0]        back_y,
   input  logic signed [SW-1:0] sim,
   input  logic signed [SW-1:0] sim_floor,
   input  logic [CW:0]          fb_limit,
   output logic                 keep
);
   logic [CW-1:0] ax, ay;
   logic [CW:0]   rt_err;

   assign ax     = (org_x >= back_x) ? (org_x - back_x) : (back_x - org_x);
   assign ay     = (org_y >= back_y) ? (org_y - back_y) : (back_y - org_y);
   assign rt_err = {1'b0, ax} + {1'b0, ay};
   assign keep   = (rt_err <= fb_limit) && (sim >= sim_floor);
endmodule

// File: rtl/trk_med_chan.sv
module trk_med_chan #(
   parameter int W     = 16,
   parameter int DEPTH = 100,
   parameter bit SGN   = 1'b1,
   parameter int NW    = 7,
   parameter int IW    = 7
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_val,
   input  logic [NW-1:0] n_used,
   input  logic [NW-1:0] rank,
   input  logic [IW-1:0] cand_idx,
   output logic          hit,
   output logic [W-1:0]  cand_val
);
   logic [W-1:0]     mem [DEPTH];
   logic [DEPTH-1:0] below, above, live;
   logic [NW-1:0]    n_lt, n_le;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_val;
   end

   assign cand_val = mem[cand_idx];

   for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      if (SGN) begin : g_signed
         assign below[j] = $signed(mem[j]) < $signed(cand_val);
         assign above[j] = $signed(mem[j]) > $signed(cand_val);
      end else begin : g_unsigned
         assign below[j] = mem[j] < cand_val;
         assign above[j] = mem[j] > cand_val;
      end
      assign live[j] = NW'(j) < n_used;
   end

   always_comb begin
      n_lt = '0;
      n_le = '0;
      for (int j = 0; j < DEPTH; j++) begin
         n_lt = n_lt + NW'(live[j] & below[j]);
         n_le = n_le + NW'(live[j] & ~above[j]);
      end
   end

   assign hit = (n_used != '0) && (n_lt <= rank) && (n_le > rank);
endmodule

// File: rtl/trk_reliability_filter.sv
module trk_reliability_filter
   import trk_pkg::*;
#(
   parameter int CW      = 12,
   parameter int RW      = 16,
   parameter int RFRAC   = 8,
   parameter int SW      = 16,
   parameter int MAX_PTS = 100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pt_valid,
   input  logic                 pt_first,
   input  logic                 pt_last,
   input  logic [CW-1:0]        org_x,
   input  logic [CW-1:0]        org_y,
   input  logic [CW-1:0]        fwd_x,
   input  logic [CW-1:0]        fwd_y,
   input  logic [CW-1:0]        back_x,
   input  logic [CW-1:0]        back_y,
   input  logic signed [SW-1:0] pt_sim,
   input  logic [RW-1:0]        pt_ratio,
   input  logic [CW:0]          fb_limit,
   input  logic signed [SW-1:0] sim_floor,
   output logic                 est_done,
   output logic                 est_ok,
   output logic signed [CW:0]   box_dx,
   output logic signed [CW:0]   box_dy,
   output logic [RW-1:0]        scale_est
);
   localparam int DW = CW + 1;
   localparam int VW = (DW > RW) ? DW : RW;
   localparam int NW = $clog2(MAX_PTS + 1);
   localparam int IW = $clog2(MAX_PTS);
   localparam logic [RW-1:0] UNITY = RW'(1) << RFRAC;

   if (MAX_PTS < 2 || MAX_PTS > 1024) begin : g_bad_depth
      $error("trk_reliability_filter: MAX_PTS must lie in 2..1024");
   end
   if (CW < 2 || SW < 2) begin : g_bad_width
      $error("trk_reliability_filter: CW and SW must be at least 2");
   end
   if (RFRAC >= RW) begin : g_bad_frac
      $error("trk_reliability_filter: RFRAC must be below RW");
   end

   trk_phase_e          phase;
   logic [NW-1:0]       n_kept, base_cnt, next_cnt, rank;
   logic [IW-1:0]       idx;
   logic                keep, accept, room, wr_en, last_cand;
   logic signed [DW-1:0] disp_x, disp_y;
   logic [VW-1:0]       wr_v   [TRK_NCH];
   logic [VW-1:0]       cand_v [TRK_NCH];
   logic [VW-1:0]       held_v [TRK_NCH];
   logic [VW-1:0]       fin_v  [TRK_NCH];
   logic [TRK_NCH-1:0]  hit;

   trk_point_gate #(.CW(CW), .SW(SW)) u_gate (
      .org_x    (org_x),
      .org_y    (org_y),
      .back_x   (back_x),
      .back_y   (back_y),
      .sim      (pt_sim),
      .sim_floor(sim_floor),
      .fb_limit (fb_limit),
      .keep     (keep)
   );

   assign disp_x        = $signed({1'b0, fwd_x}) - $signed({1'b0, org_x});
   assign disp_y        = $signed({1'b0, fwd_y}) - $signed({1'b0, org_y});
   assign wr_v[CH_DX]   = VW'(disp_x);
   assign wr_v[CH_DY]   = VW'(disp_y);
   assign wr_v[CH_RT]   = VW'(pt_ratio);

   assign base_cnt  = pt_first ? '0 : n_kept;
   assign accept    = (phase == PH_COLLECT) && pt_valid;
   assign room      = base_cnt < NW'(MAX_PTS);
   assign wr_en     = accept && keep && room;
   assign next_cnt  = wr_en ? base_cnt + NW'(1) : base_cnt;
   assign rank      = (n_kept - NW'(1)) >> 1;
   assign last_cand = (idx == IW'(n_kept - NW'(1)));

   for (genvar g = 0; g < TRK_NCH; g++) begin : g_ch
      trk_med_chan #(
         .W    (VW),
         .DEPTH(MAX_PTS),
         .SGN  (g < 2),
         .NW   (NW),
         .IW   (IW)
      ) u_med (
         .clk     (clk),
         .wr_en   (wr_en),
         .wr_idx  (IW'(base_cnt)),
         .wr_val  (wr_v[g]),
         .n_used  (n_kept),
         .rank    (rank),
         .cand_idx(idx),
         .hit     (hit[g]),
         .cand_val(cand_v[g])
      );
      assign fin_v[g] = hit[g] ? cand_v[g] : held_v[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_COLLECT;
         n_kept    <= '0;
         idx       <= '0;
         est_done  <= 1'b0;
         est_ok    <= 1'b0;
         box_dx    <= '0;
         box_dy    <= '0;
         scale_est <= UNITY;
         for (int g = 0; g < TRK_NCH; g++) held_v[g] <= '0;
      end else begin
         est_done <= 1'b0;
         case (phase)
            PH_COLLECT: begin
               if (accept) begin
                  n_kept <= next_cnt;
                  if (pt_last) begin
                     if (next_cnt == '0) begin
                        est_done  <= 1'b1;
                        est_ok    <= 1'b0;
                        box_dx    <= '0;
                        box_dy    <= '0;
                        scale_est <= UNITY;
                     end else begin
                        phase <= PH_SELECT;
                        idx   <= '0;
                     end
                  end
               end
            end
            PH_SELECT: begin
               for (int g = 0; g < TRK_NCH; g++) begin
                  if (hit[g]) held_v[g] <= cand_v[g];
               end
               idx <= idx + IW'(1);
               if (last_cand) begin
                  phase     <= PH_COLLECT;
                  est_done  <= 1'b1;
                  est_ok    <= 1'b1;
                  box_dx    <= DW'(fin_v[CH_DX]);
                  box_dy    <= DW'(fin_v[CH_DY]);
                  scale_est <= RW'(fin_v[CH_RT]);
               end
            end
            default: phase <= PH_COLLECT;
         endcase
      end
   end
endmodule

// File: rtl/trk_filter_chk.sv
module trk_filter_chk #(
   parameter int DW    = 13,
   parameter int RW    = 16,
   parameter int RFRAC = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 est_done,
   input logic                 est_ok,
   input logic signed [DW-1:0] box_dx,
   input logic signed [DW-1:0] box_dy,
   input logic [RW-1:0]        scale_est
);
   localparam logic [RW-1:0] ONE = RW'(1) << RFRAC;

   AST_EMPTY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (est_done && !est_ok) |-> (box_dx == '0 && box_dy == '0 && scale_est == ONE)); // R8
   AST_HOLD_DX: assert property (@(posedge clk) disable iff (!rst_n)
      !est_done |-> $stable(box_dx)); // R9
   AST_HOLD_DY: assert property (@(posedge clk) disable iff (!rst_n)
      !est_done |-> $stable(box_dy)); // R9
   AST_HOLD_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      !est_done |-> $stable(scale_est)); // R9
   AST_HOLD_OK: assert property (@(posedge clk) disable iff (!rst_n)
      !est_done |-> $stable(est_ok)); // R9
endmodule

bind trk_reliability_filter trk_filter_chk #(
   .DW   (CW + 1),
   .RW   (RW),
   .RFRAC(RFRAC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .est_done (est_done),
   .est_ok   (est_ok),
   .box_dx   (box_dx),
   .box_dy   (box_dy),
   .scale_est(scale_est)
);

// File: tb/trk_reliability_filter_test.sv
`timescale 1ns/1ps
module trk_reliability_filter_test;
   localparam int CW = 8, RW = 16, RFRAC = 8, SW = 16, MAXP = 6;
   localparam int UNITY = 1 << RFRAC;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                 rst_n, pt_valid, pt_first, pt_last;
   logic [CW-1:0]        org_x, org_y, fwd_x, fwd_y, back_x, back_y;
   logic signed [SW-1:0] pt_sim, sim_floor;
   logic [RW-1:0]        pt_ratio, scale_est;
   logic [CW:0]          fb_limit;
   logic                 est_done, est_ok;
   logic signed [CW:0]   box_dx, box_dy;

   trk_reliability_filter #(.CW(CW), .RW(RW), .RFRAC(RFRAC), .SW(SW), .MAX_PTS(MAXP)) uut (
      .clk(clk), .rst_n(rst_n), .pt_valid(pt_valid), .pt_first(pt_first), .pt_last(pt_last),
      .org_x(org_x), .org_y(org_y), .fwd_x(fwd_x), .fwd_y(fwd_y), .back_x(back_x), .back_y(back_y),
      .pt_sim(pt_sim), .pt_ratio(pt_ratio), .fb_limit(fb_limit), .sim_floor(sim_floor),
      .est_done(est_done), .est_ok(est_ok), .box_dx(box_dx), .box_dy(box_dy), .scale_est(scale_est)
   );

   int checks = 0, fails = 0;
   int kdx [MAXP];
   int kdy [MAXP];
   int krt [MAXP];
   int kn = 0;
   int lim_i = 0, floor_i = 0;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lower_median(int v [MAXP], int n);
      int a [MAXP];
      int tmp;
      a = v;
      for (int i = 1; i < n; i++) begin
         for (int j = i; j > 0; j--) begin
            if (a[j] < a[j-1]) begin
               tmp = a[j]; a[j] = a[j-1]; a[j-1] = tmp;
            end
         end
      end
      return a[(n - 1) / 2];
   endfunction

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic set_thresholds(int lim, int flr);
      lim_i     = lim;
      floor_i   = flr;
      fb_limit  = lim[CW:0];
      sim_floor = flr[SW-1:0];
   endtask

   task automatic send_pt(bit first, bit last, int x0, int y0, int xf, int yf,
                          int xb, int yb, int sim, int ratio);
      bit kp;
      @(negedge clk);
      pt_valid = 1'b1; pt_first = first; pt_last = last;
      org_x = x0[CW-1:0]; org_y = y0[CW-1:0];
      fwd_x = xf[CW-1:0]; fwd_y = yf[CW-1:0];
      back_x = xb[CW-1:0]; back_y = yb[CW-1:0];
      pt_sim = sim[SW-1:0]; pt_ratio = ratio[RW-1:0];
      kp = (iabs(x0 - xb) + iabs(y0 - yb) <= lim_i) && (sim >= floor_i);
      if (first) kn = 0;
      if (kp && kn < MAXP) begin
         kdx[kn] = xf - x0; kdy[kn] = yf - y0; krt[kn] = ratio; kn++;
      end
   endtask

   task automatic finish_frame(bit inject, string tag);
      bit seen = 1'b0;
      int hx, hy, hs;
      for (int t = 0; t < 40 && !seen; t++) begin
         @(negedge clk);
         if (t == 0 && inject && kn > 0) begin
            // R10: stray point while the medians are being selected
            pt_valid = 1'b1; pt_first = 1'b1; pt_last = 1'b0;
            org_x = 8'd100; org_y = 8'd100; fwd_x = 8'd200; fwd_y = 8'd10;
            back_x = 8'd100; back_y = 8'd100; pt_sim = 16'sh7fff; pt_ratio = 16'hff00;
         end else begin
            pt_valid = 1'b0; pt_first = 1'b0; pt_last = 1'b0;
         end
         if (est_done) seen = 1'b1;
      end
      check("R9", {tag, " done pulse seen"}, int'(seen), 1);
      if (kn == 0) begin
         check("R8", {tag, " ok"}, int'(est_ok), 0);
         check("R8", {tag, " dx"}, int'(box_dx), 0);
         check("R8", {tag, " dy"}, int'(box_dy), 0);
         check("R8", {tag, " scale"}, int'(scale_est), UNITY);
      end else begin
         check("R8", {tag, " ok"}, int'(est_ok), 1);
         check(inject ? "R10" : "R4", {tag, " dx"}, int'(box_dx), lower_median(kdx, kn));
         check(inject ? "R10" : "R4", {tag, " dy"}, int'(box_dy), lower_median(kdy, kn));
         check("R5", {tag, " scale"}, int'(scale_est), lower_median(krt, kn));
      end
      hx = int'(box_dx); hy = int'(box_dy); hs = int'(scale_est);
      @(negedge clk);
      pt_valid = 1'b0;
      check("R9", {tag, " done drops"}, int'(est_done), 0);
      check("R9", {tag, " dx held"}, int'(box_dx), hx);
      check("R9", {tag, " dy held"}, int'(box_dy), hy);
      check("R9", {tag, " scale held"}, int'(scale_est), hs);
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      rst_n = 1'b0; pt_valid = 1'b0; pt_first = 1'b0; pt_last = 1'b0;
      org_x = '0; org_y = '0; fwd_x = '0; fwd_y = '0; back_x = '0; back_y = '0;
      pt_sim = '0; pt_ratio = '0;
      set_thresholds(5, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset done", int'(est_done), 0);
      check("R1", "reset ok", int'(est_ok), 0);
      check("R1", "reset dx", int'(box_dx), 0);
      check("R1", "reset dy", int'(box_dy), 0);
      check("R1", "reset scale", int'(scale_est), UNITY);

      // R2: error exactly at the limit passes, one above fails
      set_thresholds(5, 0);
      send_pt(1, 1, 100, 100, 107, 96, 103, 98, 100, 300);
      finish_frame(0, "R2 at limit");
      check("R2", "limit point kept", int'(box_dx), 7);
      send_pt(1, 1, 100, 100, 107, 96, 103, 97, 100, 300);
      finish_frame(0, "R2 above limit");
      check("R2", "outlier dropped", int'(est_ok), 0);

      // R3: similarity equal to floor passes, one below fails
      set_thresholds(3, -1000);
      send_pt(1, 1, 80, 80, 70, 90, 80, 80, -1000, 270);
      finish_frame(0, "R3 at floor");
      check("R3", "floor point kept", int'(box_dy), 10);
      send_pt(1, 1, 80, 80, 70, 90, 80, 80, -1001, 270);
      finish_frame(0, "R3 below floor");
      check("R3", "low similarity dropped", int'(est_ok), 0);

      // R6: a fresh start strobe discards earlier points
      set_thresholds(4, 0);
      send_pt(1, 0, 60, 60, 90, 90, 60, 60, 500, 400);
      send_pt(0, 0, 60, 60, 91, 91, 60, 60, 500, 400);
      send_pt(1, 1, 60, 60, 55, 64, 60, 60, 500, 250);
      finish_frame(0, "R6 restart");
      check("R6", "only new frame dx", int'(box_dx), -5);

      // R4: even count takes lower middle in signed order
      send_pt(1, 0, 100, 100, 105, 100, 100, 100, 10, 256);
      send_pt(0, 0, 100, 100, 97, 100, 100, 100, 10, 300);
      send_pt(0, 0, 100, 100, 110, 100, 100, 100, 10, 200);
      send_pt(0, 1, 100, 100, 102, 100, 100, 100, 10, 280);
      finish_frame(0, "R4 even");
      check("R4", "even lower middle", int'(box_dx), 2);

      // R7: nine kept points, only the first six count
      for (int i = 0; i < 9; i++)
         send_pt(i == 0, i == 8, 100, 100, 100 + ((i < 6) ? i - 20 : 50), 100, 100, 100, 10, 256 + i);
      finish_frame(0, "R7 overflow");
      check("R7", "first six only", int'(box_dx), -18);

      // Random sweep of frames, alternate frames with a stray point (R10)
      for (int f = 0; f < 300; f++) begin
         int np;
         set_thresholds(int'($urandom_range(0, 10)), int'($urandom_range(0, 40000)) - 20000);
         np = int'($urandom_range(1, 9));
         for (int p = 0; p < np; p++) begin
            int x0, y0;
            x0 = 40 + int'($urandom_range(0, 170));
            y0 = 40 + int'($urandom_range(0, 170));
            send_pt(p == 0, p == np - 1, x0, y0,
                    x0 + int'($urandom_range(0, 60)) - 30,
                    y0 + int'($urandom_range(0, 60)) - 30,
                    x0 + int'($urandom_range(0, 8)) - 4,
                    y0 + int'($urandom_range(0, 8)) - 4,
                    int'($urandom_range(0, 65535)) - 32768,
                    200 + int'($urandom_range(0, 120)));
         end
         finish_frame(f[0], "random");
      end
      report();
   end
endmodule